// File: doc/BRIEF.md
# Serial Byte Transmitter with Frame Sync

This block sends one byte per request over a single serial line. Each byte goes out as an 11-bit frame: a low start bit, the eight data bits least significant first, an odd parity bit and a high stop bit. The byte arrives on a valid/ready handshake. A byte is taken only while the transmitter is idle, and the line stays high between frames.

The bit rate is chosen at run time from five fixed rates: 115200, 57600, 19200, 9600 and 4800 baud. The divisor for each rate is computed at elaboration as the clock frequency divided by the baud rate, rounded to the nearest integer. Each instance has its own reset-default rate, and any unused select code falls back to that rate. The select input is sampled once, when a byte is accepted, so a change on it never disturbs a frame in flight. A frame sync output is high for exactly the cycles the frame occupies on the line. Logic downstream can use it to bracket each frame.

Top module: `uart_sync_tx`

## Requirements
- R1: The select codes map 0→115200, 1→57600, 2→19200, 3→9600 and 4→4800 baud. Each of the 11 frame bits holds the line for exactly D clock cycles, where D = round(CLK_HZ / baud). The block is ready again exactly 11·D cycles after the accepting edge.
- R2: At every supported rate, the bit period D / CLK_HZ is within ±5% of 1 / baud.
- R3: Select codes 5, 6 and 7 use the rate given by the DEFAULT_RATE parameter, which is itself one of the codes 0 to 4.
- R4: Frame bit 0 (the start bit) is 0. Frame bits 1 to 8 carry data bits 0 to 7 in that order (LSB first). Frame bit 10 (the stop bit) is 1. Bits go out in frame index order. Byte 0x03 therefore gives the line sequence 0,1,1,0,0,0,0,0,0,1,1.
- R5: Frame bit 9 is the parity bit. Together with the eight data bits it makes an odd number of ones.
- R6: `frame_sync` rises in the cycle the start bit appears on the line and stays high through the stop bit. It is low in every cycle in which no frame is on the line.
- R7: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while idle. A `tx_valid` or `tx_data` change while `tx_ready` is low has no effect on the frame being sent.
- R8: The rate is taken from `rate_sel` at the accepting edge. Changes to `rate_sel` during a frame do not change that frame's bit timing.
- R9: While `rst` is high, and in the cycle after it falls, `tx_line` is 1, `frame_sync` is 0, `tx_busy` is 0 and `tx_ready` is 1. Reset asserted mid-frame aborts the frame.
- R10: The line is high whenever the block is idle. After each stop bit there is at least one idle cycle before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Rate select code, sampled when a byte is accepted |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is in progress |
| frame_sync | output | 1 | High for the duration of each frame on the line |

## Verification
The assertions assume that `rst` is a synchronous pulse of at least one cycle. They also assume that DEFAULT_RATE and CLK_HZ give divisors of at least 2, so that every bit lasts at least two cycles. The bench runs at a reduced clock frequency, so each divisor is small and exact (10 to 240 cycles) and within that range. The bench only ever raises `tx_valid` for one accepted byte at a time. It changes `rate_sel`, `tx_valid` and `tx_data` mid-frame only to show that they are ignored. It drops `tx_valid` again before the stop bit ends, so no unintended second frame starts.

// File: rtl/uart_sync_pkg.sv
package uart_sync_pkg;

    localparam int NUM_RATES  = 5;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = 11;
    localparam int SEL_W      = 3;
    localparam int SLOW_IDX   = 4;

    // Frame layout on the wire, bit 0 leaves first.
    typedef struct packed {
        logic                 stop;
        logic                 parity;
        logic [DATA_BITS-1:0] data;
        logic                 start;
    } frame_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    function automatic int baud_of(input int idx);
        case (idx)
            0:       return 115200;
            1:       return 57600;
            2:       return 19200;
            3:       return 9600;
            default: return 4800;
        endcase
    endfunction

    // Nearest-integer clock divisor for a rate index.
    function automatic int div_of(input int clk_hz, input int idx);
        int b;
        b = baud_of(idx);
        return (clk_hz + b / 2) / b;
    endfunction

    function automatic logic odd_parity(input logic [DATA_BITS-1:0] d);
        return ~(^d);
    endfunction

    function automatic frame_t build_frame(input logic [DATA_BITS-1:0] d);
        frame_t f;
        f.start  = 1'b0;
        f.data   = d;
        f.parity = odd_parity(d);
        f.stop   = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/rate_table.sv
module rate_table
    import uart_sync_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int DEFAULT_RATE = 0,
    parameter int DIV_W        = 14
) (
    input  logic [SEL_W-1:0] sel,
    output logic [DIV_W-1:0] div
);

    logic [DIV_W-1:0] tbl [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign tbl[g] = DIV_W'(div_of(CLK_HZ, g));
    end

    // Unlisted codes fall back to the instance default.
    always_comb begin
        div = tbl[DEFAULT_RATE];
        for (int i = 0; i < NUM_RATES; i++) begin
            if (sel == SEL_W'(i)) div = tbl[i];
        end
    end

endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt_q <= div_in - DIV_W'(1);
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= div_q - DIV_W'(1);
            else             cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == '0);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < div_q));

    // R8
    div_held_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !load && $past(run)) |-> $stable(div_q));

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import uart_sync_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 tick,
    output logic                 line,
    output logic                 sync,
    output logic                 busy,
    output logic                 ready
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    tx_state_e              state_q;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic [CNT_W-1:0]       idx_q;
    logic                   line_q;
    logic                   sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '1;
            idx_q   <= '0;
            line_q  <= 1'b1;
            sync_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        shreg_q <= build_frame(data);
                        line_q  <= 1'b0;
                        idx_q   <= '0;
                        sync_q  <= 1'b1;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (idx_q == CNT_W'(FRAME_BITS - 1)) begin
                            line_q  <= 1'b1;
                            sync_q  <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                            line_q  <= shreg_q[1];
                            idx_q   <= idx_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign line  = line_q;
    assign sync  = sync_q;
    assign busy  = (state_q == ST_SEND);
    assign ready = (state_q == ST_IDLE);

    // R6
    sync_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync) |-> !line);

    // R10
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (line && !sync));

    // R7
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && ready) |=> (busy && !line && sync));

    // R4
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q == CNT_W'(FRAME_BITS - 1)) |-> line);

endmodule

// File: rtl/uart_sync_tx.sv
module uart_sync_tx
    import uart_sync_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int DEFAULT_RATE = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       tx_line,
    output logic       tx_busy,
    output logic       frame_sync
);

    localparam int DIV_W = $clog2(div_of(CLK_HZ, SLOW_IDX) + 1);

    logic [DIV_W-1:0] sel_div;
    logic             accept;
    logic             tick;

    assign accept = tx_valid && tx_ready;

    rate_table #(
        .CLK_HZ       (CLK_HZ),
        .DEFAULT_RATE (DEFAULT_RATE),
        .DIV_W        (DIV_W)
    ) u_rates (
        .sel (rate_sel),
        .div (sel_div)
    );

    bit_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .div_in (sel_div),
        .run    (tx_busy),
        .tick   (tick)
    );

    frame_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .data   (tx_data),
        .tick   (tick),
        .line   (tx_line),
        .sync   (frame_sync),
        .busy   (tx_busy),
        .ready  (tx_ready)
    );

    // R7
    ready_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready != tx_busy);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (tx_ready && tx_line && !frame_sync));

endmodule

// File: tb/uart_sync_tx_test.sv
`timescale 1ns/1ps
module uart_sync_tx_test;

    localparam int CLK_HZ = 1_152_000;
    localparam int DEF    = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] rate_sel;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready, tx_line, tx_busy, frame_sync;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_sync_tx #(.CLK_HZ(CLK_HZ), .DEFAULT_RATE(DEF)) uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
        .tx_busy(tx_busy), .frame_sync(frame_sync)
    );

    function automatic int baud(input int idx);
        int t [5] = '{115200, 57600, 19200, 9600, 4800};
        return t[idx];
    endfunction

    function automatic int exp_div(input int code);
        int idx = (code < 5) ? code : DEF;
        return (CLK_HZ + baud(idx) / 2) / baud(idx);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one byte and check every bit mid-period plus the exact frame length.
    task automatic send(input logic [7:0] d, input int code, input bit disturb);
        int dv = exp_div(code);
        logic [10:0] f = {1'b1, ~(^d), d, 1'b0};
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1; rate_sel = 3'(code);
        @(posedge clk); #1;
        tx_valid = 1'b0;
        for (int k = 0; k < 11; k++) begin
            repeat ((k == 0) ? dv / 2 : dv) @(posedge clk);
            #1;
            check(tx_line == f[k], (k == 9) ? "R5 parity" : "R4 frame bit",
                  int'(tx_line), int'(f[k]));
            check(frame_sync && tx_busy && !tx_ready, "R6/R7 in-frame state",
                  int'({frame_sync, tx_busy, tx_ready}), 3'b110);
            if (disturb && k == 2) begin
                tx_valid = 1'b1; tx_data = ~d; rate_sel = 3'((code + 3) % 8);
            end
            if (disturb && k == 5) tx_valid = 1'b0;
        end
        repeat (dv - dv / 2 - 1) @(posedge clk);
        #1;
        check(!tx_ready && tx_line && frame_sync, "R1 R8 last stop cycle",
              int'({tx_ready, tx_line, frame_sync}), 3'b011);
        @(posedge clk); #1;
        check(tx_ready && tx_line && !frame_sync && !tx_busy, "R1 R10 back to idle",
              int'({tx_ready, tx_line, frame_sync, tx_busy}), 4'b1100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; tx_valid = 1'b0; tx_data = '0; rate_sel = '0;
        repeat (3) @(posedge clk);
        #1;
        check(tx_ready && tx_line && !frame_sync && !tx_busy, "R9 in reset",
              int'({tx_ready, tx_line, frame_sync, tx_busy}), 4'b1100);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(tx_ready && tx_line && !frame_sync, "R9 after reset",
              int'({tx_ready, tx_line, frame_sync}), 3'b110);

        // R2: tolerance of each nominal rate against the exact divisor used.
        for (int c = 0; c < 5; c++) begin
            int err = exp_div(c) * baud(c) - CLK_HZ;
            if (err < 0) err = -err;
            check(err * 20 <= CLK_HZ, "R2 rate tolerance", err, CLK_HZ / 20);
        end

        // R4: the 0x03 example.
        send(8'h03, 0, 1'b0);

        // R1 R4 R5: every byte at the fastest rate.
        for (int b = 0; b < 256; b++) send(8'(b), 0, 1'b0);

        // R1 R3 R7 R8: every code, with disturbance mid-frame.
        for (int c = 1; c < 8; c++) begin
            send(8'hA5, c, 1'b0);
            send(8'h80, c, 1'b1);
        end
        send(8'h00, 4, 1'b1);

        // R9: reset aborts a frame in flight.
        @(negedge clk);
        tx_data = 8'h00; tx_valid = 1'b1; rate_sel = 3'd3;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check(tx_ready && tx_line && !frame_sync && !tx_busy, "R9 mid-frame reset",
              int'({tx_ready, tx_line, frame_sync, tx_busy}), 4'b1100);
        @(negedge clk); rst = 1'b0;
        send(8'h5C, 1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule